// File: doc/BRIEF.md
# Branch Condition and Jump Target Unit

This unit settles every control transfer that an integer pipeline meets at execute: the six conditional branches and the two jumps (pc-relative jump-and-link and register-indirect jump-and-link). For each valid request it reports whether the transfer is taken and the next program counter. It also reports the return address that a jump writes to its destination register, whether that write happens, and whether a taken target is not word aligned.

All results are registered, so they appear one clock after the request. A two-state stage controller tracks whether the result register holds a live result. The states are `ST_EMPTY` (no result) and `ST_HELD` (result valid). The transitions are: `ST_EMPTY -> ST_HELD` when a request arrives, `ST_HELD -> ST_HELD` when a new request follows at once, and `ST_HELD -> ST_EMPTY` on a cycle with no request. Reset forces `ST_EMPTY`.

The offset input arrives already sign-extended to the datapath width. For the conditional branches and the pc-relative jump it is a byte offset with bit 0 clear. For the indirect jump it is the 12-bit immediate, which may be odd.

Top module: `ctl_xfer_unit`

## Requirements
- R1: After reset, and until the first request, `res_valid`, `res_taken`, `res_link_we` and `res_misalign` are 0.
- R2: Operation code 0 (equal) is taken when `src_a == src_b`. Operation code 1 (not equal) is taken when they differ.
- R3: Operation code 2 (signed less) is taken when `src_a < src_b` as two's-complement numbers. Operation code 3 (signed greater-or-equal) is taken in the opposite case.
- R4: Operation code 4 (unsigned less) is taken when `src_a < src_b` as unsigned numbers. Operation code 5 (unsigned greater-or-equal) is taken in the opposite case.
- R5: A taken branch (codes 0..5) targets `pc + offset` modulo 2^XLEN. A branch that is not taken targets `pc + 4`. A branch never asserts `res_link_we`.
- R6: Operation code 6 (pc-relative jump) is always taken and targets `pc + offset` modulo 2^XLEN, including across address wrap.
- R7: Operation code 7 (indirect jump) is always taken and targets `src_a + offset` with bit 0 forced to 0.
- R8: `res_link` equals `pc + 4` for every request. `res_link_we` is 1 only for codes 6 and 7 with a nonzero `dst_idx`.
- R9: `res_misalign` is 1 exactly when the transfer is taken and bit 1 of the target is 1. A branch that is not taken never flags.
- R10: Results appear on the clock after the request. On a cycle that follows no request, `res_valid`, `res_taken`, `res_link_we` and `res_misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code, 0..7 as in R2-R7 |
| src_a | input | XLEN | First register operand |
| src_b | input | XLEN | Second register operand |
| pc_in | input | XLEN | Address of the transfer instruction |
| offset_in | input | XLEN | Sign-extended offset or immediate |
| dst_idx | input | RIDX_W | Destination register index |
| res_valid | output | 1 | Result register holds a live result |
| res_taken | output | 1 | Transfer is taken |
| res_next_pc | output | XLEN | Next program counter |
| res_link | output | XLEN | Return address, pc + 4 |
| res_link_we | output | 1 | Return address is to be written |
| res_misalign | output | 1 | Taken target is not 4-byte aligned |

## Verification
The assertions assume a 3-bit code, so every value of `req_op` is a legal operation. They also assume that the offsets for codes 0..6 keep bit 0 clear. This assumption matters because the misalignment and link checks reason only about bit 1 and about the pc increment. The stimulus drives only even offsets for branches and pc-relative jumps, and it gives odd values only to the indirect jump, where the design must clear bit 0 itself. The request inputs change on the falling edge, so every assertion sees stable values at the rising edge.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        XF_EQ   = 3'd0,
        XF_NE   = 3'd1,
        XF_LT   = 3'd2,
        XF_GE   = 3'd3,
        XF_LTU  = 3'd4,
        XF_GEU  = 3'd5,
        XF_JREL = 3'd6,
        XF_JIND = 3'd7
    } xfer_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } stage_e;

endpackage

// File: rtl/xfer_cond.sv
module xfer_cond
    import xfer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  xfer_op_e     op,
    output logic         cond_met
);
    logic same;
    logic less_s;
    logic less_u;

    assign same   = (a == b);
    assign less_s = ($signed(a) < $signed(b));
    assign less_u = (a < b);

    always_comb begin
        unique case (op)
            XF_EQ:   cond_met = same;
            XF_NE:   cond_met = !same;
            XF_LT:   cond_met = less_s;
            XF_GE:   cond_met = !less_s;
            XF_LTU:  cond_met = less_u;
            XF_GEU:  cond_met = !less_u;
            default: cond_met = 1'b1;
        endcase
    end
endmodule

// File: rtl/xfer_target.sv
module xfer_target #(
    parameter int W = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] base_reg,
    input  logic [W-1:0] offset,
    input  logic         indirect,
    input  logic         take,
    output logic [W-1:0] target,
    output logic [W-1:0] seq_pc
);
    localparam logic [W-1:0] STEP     = W'(INSN_BYTES);
    localparam logic [W-1:0] CLR_LSB  = ~W'(1);

    logic [W-1:0] base;
    logic [W-1:0] sum;
    logic [W-1:0] jump_tgt;

    assign base     = indirect ? base_reg : pc;
    assign sum      = base + offset;
    assign jump_tgt = indirect ? (sum & CLR_LSB) : sum;
    assign seq_pc   = pc + STEP;
    assign target   = take ? jump_tgt : seq_pc;
endmodule

// File: rtl/ctl_xfer_unit.sv
module ctl_xfer_unit
    import xfer_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   offset_in,
    input  logic [RIDX_W-1:0] dst_idx,
    output logic              res_valid,
    output logic              res_taken,
    output logic [XLEN-1:0]   res_next_pc,
    output logic [XLEN-1:0]   res_link,
    output logic              res_link_we,
    output logic              res_misalign
);
    localparam logic [XLEN-1:0] INSN_STEP = XLEN'(4);

    xfer_op_e    op;
    stage_e      state_q;
    stage_e      state_d;
    logic        is_jump;
    logic        cond_met;
    logic        take_c;
    logic        we_c;
    logic        mis_c;
    logic [XLEN-1:0] tgt_c;
    logic [XLEN-1:0] seq_c;

    assign op      = xfer_op_e'(req_op);
    assign is_jump = (op == XF_JREL) || (op == XF_JIND);

    xfer_cond #(.W(XLEN)) u_cond (
        .a        (src_a),
        .b        (src_b),
        .op       (op),
        .cond_met (cond_met)
    );

    assign take_c = is_jump || cond_met;

    xfer_target #(.W(XLEN), .INSN_BYTES(4)) u_tgt (
        .pc       (pc_in),
        .base_reg (src_a),
        .offset   (offset_in),
        .indirect (op == XF_JIND),
        .take     (take_c),
        .target   (tgt_c),
        .seq_pc   (seq_c)
    );

    assign we_c  = is_jump && (dst_idx != '0);
    assign mis_c = take_c && tgt_c[1];

    // stage controller: next state
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = req_valid ? ST_HELD : ST_EMPTY;
            ST_HELD:  state_d = req_valid ? ST_HELD : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    assign res_valid = (state_q == ST_HELD);

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_taken    <= 1'b0;
            res_next_pc  <= '0;
            res_link     <= '0;
            res_link_we  <= 1'b0;
            res_misalign <= 1'b0;
        end else if (req_valid) begin
            res_taken    <= take_c;
            res_next_pc  <= tgt_c;
            res_link     <= seq_c;
            res_link_we  <= we_c;
            res_misalign <= mis_c;
        end else begin
            res_taken    <= 1'b0;
            res_link_we  <= 1'b0;
            res_misalign <= 1'b0;
        end
    end

    a_r8_write_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
        res_link_we |-> (res_taken && res_valid));

    a_r9_flag_only_taken: assert property (@(posedge clk) disable iff (!rst_n)
        res_misalign |-> (res_taken && res_valid));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_taken && !res_link_we && !res_misalign));

    a_r8_link_is_pc_plus4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_link == $past(pc_in) + INSN_STEP));

    a_r7_indirect_even: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd7) |=> (!res_next_pc[0] && res_taken));

    a_r5_branch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[2:1] != 2'b11) |=> !res_link_we);

    a_r10_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
endmodule

// File: tb/ctl_xfer_unit_test.sv
module ctl_xfer_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] src_a = '0, src_b = '0, pc_in = '0, offset_in = '0;
    logic [4:0]  dst_idx = '0;
    logic        res_valid, res_taken, res_link_we, res_misalign;
    logic [31:0] res_next_pc, res_link;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_xfer_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .src_a(src_a), .src_b(src_b), .pc_in(pc_in), .offset_in(offset_in),
        .dst_idx(dst_idx), .res_valid(res_valid), .res_taken(res_taken),
        .res_next_pc(res_next_pc), .res_link(res_link),
        .res_link_we(res_link_we), .res_misalign(res_misalign)
    );

    // behavioural reference: returns {valid,taken,we,mis} and target/link
    task automatic step(input logic v, input int op, input longint a, input longint b,
                        input longint pc, input longint off, input int rd, input string tag);
        longint sa, sb, ua, ub, tgt, lnk;
        bit tk, we, mis;
        @(negedge clk);
        req_valid = v; req_op = 3'(op);
        src_a = a[31:0]; src_b = b[31:0]; pc_in = pc[31:0];
        offset_in = off[31:0]; dst_idx = 5'(rd);
        ua = a & 64'hFFFF_FFFF; ub = b & 64'hFFFF_FFFF;
        sa = (ua >= 64'h8000_0000) ? ua - 64'h1_0000_0000 : ua;
        sb = (ub >= 64'h8000_0000) ? ub - 64'h1_0000_0000 : ub;
        case (op)
            0: tk = (ua == ub);
            1: tk = (ua != ub);
            2: tk = (sa < sb);
            3: tk = (sa >= sb);
            4: tk = (ua < ub);
            5: tk = (ua >= ub);
            default: tk = 1'b1;
        endcase
        lnk = (pc + 4) & 64'hFFFF_FFFF;
        if (op == 7)  tgt = ((a + off) & 64'hFFFF_FFFF) & ~64'd1;
        else if (tk)  tgt = (pc + off) & 64'hFFFF_FFFF;
        else          tgt = lnk;
        we  = (op >= 6) && (rd != 0);
        mis = tk && ((tgt & 2) != 0);
        if (!v) begin tk = 0; we = 0; mis = 0; end
        @(posedge clk); #1;
        n_run++;
        if (res_valid !== v || res_taken !== tk || res_link_we !== we || res_misalign !== mis ||
            (v && (res_next_pc !== tgt[31:0] || res_link !== lnk[31:0]))) begin
            n_fail++;
            $display("FAIL %s: got v=%0b tk=%0b we=%0b mis=%0b pc=%h lnk=%h, exp v=%0b tk=%0b we=%0b mis=%0b pc=%h lnk=%h",
                     tag, res_valid, res_taken, res_link_we, res_misalign, res_next_pc, res_link,
                     v, tk, we, mis, tgt[31:0], lnk[31:0]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (res_valid !== 0 || res_taken !== 0 || res_link_we !== 0 || res_misalign !== 0) begin
            n_fail++;
            $display("FAIL R1 reset: got %0b%0b%0b%0b expected 0000",
                     res_valid, res_taken, res_link_we, res_misalign);
        end
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
        step(1, 0, 32'h1234, 32'h1234, 32'h100, 32'h40, 3, "R2 eq taken");
        step(1, 0, 32'h1234, 32'h1235, 32'h100, 32'h40, 3, "R2 eq not taken R5");
        step(1, 1, 32'h7, 32'h8, 32'h200, 32'hFFFF_FFF0, 0, "R2 ne taken backward");
        step(1, 1, 32'h8, 32'h8, 32'h200, 32'h10, 0, "R2 ne not taken");
        step(1, 2, 32'hFFFF_FFFF, 32'h1, 32'h300, 32'h20, 0, "R3 lt neg<pos");
        step(1, 3, 32'h8000_0000, 32'h7FFF_FFFF, 32'h300, 32'h20, 0, "R3 ge min not taken");
        step(1, 3, 32'h55, 32'h55, 32'h300, 32'h24, 0, "R3 ge equal taken");
        step(1, 4, 32'hFFFF_FFFF, 32'h1, 32'h400, 32'h20, 0, "R4 ltu big not taken");
        step(1, 4, 32'h0, 32'h1, 32'h400, 32'h20, 0, "R4 ltu zero taken");
        step(1, 5, 32'hFFFF_FFFF, 32'h1, 32'h400, 32'h8, 0, "R4 geu taken");
        step(0, 6, 0, 0, 32'h500, 32'h8, 1, "R10 idle gap");
        step(1, 6, 0, 0, 32'h1000, 32'h800, 1, "R6 jal link R8");
        step(1, 6, 0, 0, 32'h1000, 32'h800, 0, "R8 plain jump no write");
        step(1, 6, 0, 0, 32'hFFFF_FFFC, 32'h8, 5, "R6 jal wrap");
        step(1, 7, 32'h1001, 0, 32'h2000, 32'h0, 1, "R7 jalr clear lsb");
        step(1, 7, 32'h3000, 0, 32'h2000, 32'hFFFF_F805, 0, "R7 jalr negative odd imm R8");
        step(1, 6, 0, 0, 32'h100, 32'h2, 1, "R9 jal misaligned");
        step(1, 7, 32'h4002, 0, 32'h100, 32'h1, 2, "R9 jalr misaligned");
        step(1, 0, 32'h1, 32'h2, 32'h100, 32'h2, 0, "R9 not taken no flag");
        step(1, 0, 32'h9, 32'h9, 32'h100, 32'h6, 0, "R9 taken branch flag");
        step(0, 0, 0, 0, 0, 0, 0, "R10 idle clears");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule